// File: doc/BRIEF.md
# Sprite DMA Snooping Copy Engine

This engine sits on the cartridge side of the console's CPU bus and listens in on the 256-byte sprite DMA transfer. Each time the CPU starts such a transfer, the engine tracks the bus traffic. It takes every byte the DMA reads from its source page and writes it into a cartridge-side target RAM. A per-byte descriptor table chooses the target address. The console's fixed-destination copy therefore also acts as a scatter copy into a second memory at no extra CPU cost.

Each descriptor is 16 bits wide. Bits 15..14 hold the step mode and bits 11..0 hold an absolute target address. The mode can advance the running 12-bit address by one, advance it by one row of 32, or load the absolute address. Snooping stays off until the CPU sets a control bit. While it is off, sprite DMA runs with no side effect.

The bus is presented as one qualified CPU cycle per clock in which `cpuStb` is high. The descriptor table and the target RAM are outside the block. The table is read combinationally through `descIdx` and `descData`.

Top module: `snoop_copy_engine`

## Requirements
- R1: After reset, `tgtWe` is 0 and snooping is disabled.
- R2: A CPU write to the control address (default $5FF0) sets the enable from data bit 0. While the enable is 0, a transfer issues no target write.
- R3: Only a write cycle (`cpuRw` = 0) to $4014 arms a transfer. A read of $4014 arms nothing.
- R4: Once a transfer is armed, the byte written to the target is the data seen on the last read cycle before each write cycle. One extra alignment read at the start does not shift the byte order.
- R5: Descriptor mode 00 writes to the previous target address plus 1.
- R6: Descriptor mode 01 writes to the previous target address plus 32.
- R7: Descriptor mode 10 writes to descriptor bits 11..0. Reserved mode 11 behaves as mode 00.
- R8: If the first descriptor of a transfer is not mode 10, the first byte goes to address 0, and later steps count on from there.
- R9: The target address is 12 bits wide and wraps modulo 4096.
- R10: An armed transfer issues exactly 256 target writes and then returns to idle. Further write cycles issue no writes until the next arming.
- R11: `descIdx` equals the index of the byte being written. `tgtWe` pulses for one clock, one clock after the CPU write cycle, and `tgtAddr` and `tgtData` are valid with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuStb | input | 1 | Qualifies one CPU bus cycle in this clock |
| cpuAddr | input | 16 | CPU address bus |
| cpuData | input | 8 | CPU data bus |
| cpuRw | input | 1 | 1 = read cycle, 0 = write cycle |
| descIdx | output | 8 | Descriptor table read index |
| descData | input | 16 | Descriptor read back for `descIdx` |
| tgtWe | output | 1 | Target RAM write enable |
| tgtAddr | output | 12 | Target RAM write address |
| tgtData | output | 8 | Target RAM write data |

## Verification
Two conditions are hard to reach from the ports: the address wrap and the boundary between the alignment read and the first real byte. Both appear only deep inside a full 512-cycle transfer. The bench therefore builds descriptor tables that start an absolute address just below the top of the 12-bit space and follow it with row steps. It runs the same copy both with and without an extra alignment read. On each write cycle, the bench drives data that differs from the byte read just before. A design that captured the wrong cycle would then write visibly wrong data.

// File: rtl/snoop_copy_pkg.sv
package snoop_copy_pkg;
  typedef enum logic [1:0] {
    MODE_INC1  = 2'b00,
    MODE_INC32 = 2'b01,
    MODE_ABS   = 2'b10,
    MODE_RSV   = 2'b11
  } descMode_e;

  typedef struct packed {
    logic latchByte;
    logic commit;
    logic firstByte;
  } ctrlStrobe_t;
endpackage

// File: rtl/snoop_copy_ctrl.sv
module snoop_copy_ctrl
  import snoop_copy_pkg::*;
#(
  parameter logic [15:0] DMA_ADDR  = 16'h4014,
  parameter logic [15:0] CTRL_ADDR = 16'h5FF0,
  parameter int          BYTES     = 256,
  localparam int         IDX_W     = $clog2(BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuStb,
  input  logic [15:0]      cpuAddr,
  input  logic             cpuEnBit,
  input  logic             cpuRw,
  output ctrlStrobe_t      strobe,
  output logic [IDX_W-1:0] byteIdx
);
  logic             snoopEn;
  logic             active;
  logic [IDX_W-1:0] cnt;
  logic             busWrite;
  logic             busRead;
  logic             armHit;
  logic             lastByte;

  assign busWrite = cpuStb && !cpuRw;
  assign busRead  = cpuStb && cpuRw;
  assign armHit   = busWrite && (cpuAddr == DMA_ADDR) && snoopEn && !active;
  assign lastByte = (cnt == IDX_W'(BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snoopEn <= 1'b0;
      active  <= 1'b0;
      cnt     <= '0;
    end else begin
      if (busWrite && cpuAddr == CTRL_ADDR) snoopEn <= cpuEnBit;
      if (armHit) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active && busWrite) begin
        if (lastByte) begin
          active <= 1'b0;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.latchByte = active && busRead;
    strobe.commit    = active && busWrite;
    strobe.firstByte = (cnt == '0);
  end

  assign byteIdx = cnt;

  assert_disabled_no_arm_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!snoopEn && !active) |=> !active);

  assert_read_no_arm_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !busWrite) |=> !active);

  assert_end_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (active && busWrite && lastByte) |=> !active);

  assert_index_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (active && !busWrite) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/snoop_copy_datapath.sv
module snoop_copy_datapath
  import snoop_copy_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int ROW_STEP = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [7:0]        cpuData,
  input  logic [15:0]       descData,
  output logic              tgtWe,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic [7:0]        tgtData
);
  descMode_e         descMode;
  logic [ADDR_W-1:0] descAbs;
  logic [ADDR_W-1:0] addrCnt;
  logic [ADDR_W-1:0] nextAddr;
  logic [7:0]        holdByte;

  assign descMode = descMode_e'(descData[15:14]);
  assign descAbs  = descData[ADDR_W-1:0];

  always_comb begin
    if (strobe.firstByte) begin
      nextAddr = (descMode == MODE_ABS) ? descAbs : '0;
    end else begin
      unique case (descMode)
        MODE_INC32: nextAddr = addrCnt + ADDR_W'(ROW_STEP);
        MODE_ABS:   nextAddr = descAbs;
        default:    nextAddr = addrCnt + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdByte <= '0;
      addrCnt  <= '0;
      tgtWe    <= 1'b0;
      tgtAddr  <= '0;
      tgtData  <= '0;
    end else begin
      if (strobe.latchByte) holdByte <= cpuData;
      tgtWe <= strobe.commit;
      if (strobe.commit) begin
        addrCnt <= nextAddr;
        tgtAddr <= nextAddr;
        tgtData <= holdByte;
      end
    end
  end

  assert_we_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> tgtWe);

  assert_inc32_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !strobe.firstByte && descMode == MODE_INC32)
      |=> (tgtAddr == $past(tgtAddr) + ADDR_W'(ROW_STEP)));

  assert_inc1_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !strobe.firstByte && descMode == MODE_INC1)
      |=> (tgtAddr == $past(tgtAddr) + 1'b1));

  assert_abs_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && descMode == MODE_ABS) |=> (tgtAddr == $past(descAbs)));
endmodule

// File: rtl/snoop_copy_engine.sv
module snoop_copy_engine
  import snoop_copy_pkg::*;
#(
  parameter logic [15:0] DMA_ADDR  = 16'h4014,
  parameter logic [15:0] CTRL_ADDR = 16'h5FF0,
  parameter int          BYTES     = 256,
  parameter int          ADDR_W    = 12,
  parameter int          ROW_STEP  = 32,
  localparam int         IDX_W     = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuStb,
  input  logic [15:0]       cpuAddr,
  input  logic [7:0]        cpuData,
  input  logic              cpuRw,
  output logic [IDX_W-1:0]  descIdx,
  input  logic [15:0]       descData,
  output logic              tgtWe,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic [7:0]        tgtData
);
  ctrlStrobe_t strobe;

  snoop_copy_ctrl #(
    .DMA_ADDR (DMA_ADDR),
    .CTRL_ADDR(CTRL_ADDR),
    .BYTES    (BYTES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cpuStb  (cpuStb),
    .cpuAddr (cpuAddr),
    .cpuEnBit(cpuData[0]),
    .cpuRw   (cpuRw),
    .strobe  (strobe),
    .byteIdx (descIdx)
  );

  snoop_copy_datapath #(
    .ADDR_W  (ADDR_W),
    .ROW_STEP(ROW_STEP)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cpuData (cpuData),
    .descData(descData),
    .tgtWe   (tgtWe),
    .tgtAddr (tgtAddr),
    .tgtData (tgtData)
  );
endmodule

// File: tb/snoop_copy_engine_bench.sv
module snoop_copy_engine_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cpuStb;
  logic [15:0] cpuAddr;
  logic [7:0]  cpuData;
  logic        cpuRw;
  logic [7:0]  descIdx;
  logic [15:0] descData;
  logic        tgtWe;
  logic [11:0] tgtAddr;
  logic [7:0]  tgtData;

  logic [15:0] descMem [256];
  logic [11:0] wAddr [512];
  logic [7:0]  wData [512];
  logic [7:0]  wIdx  [512];
  int wCnt = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  assign descData = descMem[descIdx];

  snoop_copy_engine u_snoop_copy_engine (
    .clk(clk), .rstN(rstN), .cpuStb(cpuStb), .cpuAddr(cpuAddr),
    .cpuData(cpuData), .cpuRw(cpuRw), .descIdx(descIdx), .descData(descData),
    .tgtWe(tgtWe), .tgtAddr(tgtAddr), .tgtData(tgtData)
  );

  // Record the descriptor index on each write cycle, and each target write one clock later.
  always @(negedge clk) begin
    if (tgtWe && wCnt < 512) begin
      wAddr[wCnt] = tgtAddr;
      wData[wCnt] = tgtData;
      wCnt++;
    end
    if (cpuStb && !cpuRw && wCnt < 512) wIdx[wCnt] = descIdx;
  end

  function automatic logic [7:0] srcOf(int i, int seed);
    return 8'((i * 7 + seed) & 8'hFF);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busCycle(logic [15:0] a, logic [7:0] d, logic rw);
    @(negedge clk);
    cpuStb = 1'b1; cpuAddr = a; cpuData = d; cpuRw = rw;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cpuStb = 1'b0; cpuRw = 1'b1; cpuAddr = '0; cpuData = '0;
    end
  endtask

  task automatic setEnable(bit en);
    busCycle(16'h5FF0, {7'd0, en}, 1'b0);
    idle(1);
  endtask

  // Full sprite DMA: arm write, halt read, optional alignment read, 256 read/write pairs.
  task automatic runDma(bit align, int seed);
    wCnt = 0;
    busCycle(16'h4014, 8'h02, 1'b0);
    busCycle(16'h4014, 8'h5A, 1'b1);
    if (align) busCycle(16'h0200, 8'hC3, 1'b1);
    for (int i = 0; i < 256; i++) begin
      busCycle(16'h0200 + 16'(i), srcOf(i, seed), 1'b1);
      busCycle(16'h2004, ~srcOf(i, seed), 1'b0);
    end
    idle(3);
  endtask

  task automatic checkCopy(string tag, int seed);
    logic [11:0] cur;
    int addrBad = 0, dataBad = 0, idxBad = 0;
    int firstA = -1, expA = 0, actA = 0, firstD = -1, expD = 0, actD = 0;
    check(wCnt == 256, {tag, " R10 write count"}, wCnt, 256);
    cur = '0;
    for (int i = 0; i < 256 && i < wCnt; i++) begin
      logic [1:0]  m;
      logic [11:0] a;
      m = descMem[i][15:14];
      a = descMem[i][11:0];
      if (i == 0) cur = (m == 2'b10) ? a : 12'h000;
      else if (m == 2'b01) cur = cur + 12'd32;
      else if (m == 2'b10) cur = a;
      else cur = cur + 12'd1;
      if (wAddr[i] != cur) begin
        addrBad++;
        if (firstA < 0) begin firstA = i; expA = cur; actA = wAddr[i]; end
      end
      if (wData[i] != srcOf(i, seed)) begin
        dataBad++;
        if (firstD < 0) begin firstD = i; expD = srcOf(i, seed); actD = wData[i]; end
      end
      if (wIdx[i] != 8'(i)) idxBad++;
    end
    check(addrBad == 0, {tag, " R5 R6 R7 R8 R9 address sequence"}, actA, expA);
    check(dataBad == 0, {tag, " R4 captured bytes"}, actD, expD);
    check(idxBad == 0, {tag, " R11 descriptor index"}, idxBad, 0);
  endtask

  task automatic testReset();
    check(tgtWe == 1'b0, "R1 tgtWe after reset", tgtWe, 0);
    wCnt = 0;
    busCycle(16'h4014, 8'h02, 1'b0);
    for (int i = 0; i < 8; i++) begin
      busCycle(16'h0200, 8'h11, 1'b1);
      busCycle(16'h2004, 8'h22, 1'b0);
    end
    idle(3);
    check(wCnt == 0, "R1 snooping off after reset", wCnt, 0);
  endtask

  task automatic testReadNoArm();
    setEnable(1'b1);
    wCnt = 0;
    busCycle(16'h4014, 8'h02, 1'b1);
    for (int i = 0; i < 8; i++) begin
      busCycle(16'h0200, 8'h33, 1'b1);
      busCycle(16'h2004, 8'h44, 1'b0);
    end
    idle(3);
    check(wCnt == 0, "R3 read of $4014 arms nothing", wCnt, 0);
  endtask

  task automatic testLinear();
    for (int i = 0; i < 256; i++) descMem[i] = (i == 0) ? 16'h8100 : 16'h0000;
    runDma(1'b0, 5);
    checkCopy("linear", 5);
    check(wAddr[255] == 12'h1FF, "R5 last linear address", wAddr[255], 12'h1FF);
  endtask

  task automatic testMixed(bit align);
    for (int i = 0; i < 256; i++) begin
      if (i == 0) descMem[i] = 16'h8FE0;
      else if (i < 4) descMem[i] = 16'h4000;
      else if (i % 7 == 3) descMem[i] = 16'h8000 | 16'((i * 13) & 12'hFFF);
      else if (i % 5 == 1) descMem[i] = 16'h4000;
      else if (i % 5 == 2) descMem[i] = 16'hC000;
      else descMem[i] = 16'h0000;
    end
    runDma(align, align ? 77 : 19);
    checkCopy(align ? "mixed aligned" : "mixed", align ? 77 : 19);
    check(wAddr[1] == 12'h000, "R9 wrap on row step", wAddr[1], 0);
  endtask

  task automatic testNoAbsFirst();
    for (int i = 0; i < 256; i++) descMem[i] = (i % 3 == 0) ? 16'h4000 : 16'h0000;
    descMem[0] = 16'h0ABC;
    runDma(1'b1, 101);
    checkCopy("noabs", 101);
    check(wAddr[0] == 12'h000, "R8 first write at zero", wAddr[0], 0);
    wCnt = 0;
    for (int i = 0; i < 6; i++) begin
      busCycle(16'h0200, 8'h55, 1'b1);
      busCycle(16'h2004, 8'h66, 1'b0);
    end
    idle(3);
    check(wCnt == 0, "R10 idle after 256 writes", wCnt, 0);
  endtask

  task automatic testDisabled();
    setEnable(1'b0);
    runDma(1'b0, 3);
    check(wCnt == 0, "R2 disabled transfer has no writes", wCnt, 0);
    check(tgtWe == 1'b0, "R2 tgtWe low while disabled", tgtWe, 0);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) descMem[i] = '0;
    rstN = 1'b0; cpuStb = 1'b0; cpuAddr = '0; cpuData = '0; cpuRw = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadNoArm();
    testLinear();
    testMixed(1'b0);
    testMixed(1'b1);
    testNoAbsFirst();
    testDisabled();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule